// File: doc/BRIEF.md
# Windowed Command and Interrupt Register

This unit sits on the slave side of a network adapter. It serves a single 16-bit register offset that every register window shares. A write to that offset is taken as a command word: a 5-bit opcode in bits [15:11] over an 11-bit argument in bits [10:0]. Reading the offset always returns the interrupt status word, with the number of the selected register window in the top three bits. The unit holds four pieces of state: the current window, the interrupt-enable mask, the indication mask and the latched event bits. From these it drives a level interrupt request line.

The unit decides which opcodes it handles itself and which it hands on. It handles window selection, interrupt request, acknowledge and the loading of both masks. Every other accepted command goes to the surrounding datapaths as a one-cycle strobe, with the opcode and argument attached. The reset and discard commands also raise a command-in-progress flag for a fixed number of cycles. While that flag is high, all further writes are ignored.

Top module: `cmdint_regs`

## Requirements
- R1: After reset, the window is 0 and both masks are 0. `irq`, `cmd_busy` and `exec_stb` are 0, and `rd_data` reads 0x0000.
- R2: Opcode 1 loads the window from argument bits [2:0]. From the cycle after the write, `rd_data[15:13]` and `win_sel` show the new window.
- R3: Opcode 14 loads the enable mask and opcode 15 loads the indication mask, each from argument bits [8:0]. `rd_data` bits [8:0] read as the internal bit AND its indication bit. Internal bit 0 is the interrupt latch and bits 1..8 are the event bits.
- R4: A pulse on `evt_in[k]` sets status bit k+1. Bit 2 is tx complete, bit 4 is rx complete and bit 1 is host error. The bit stays set until it is acknowledged.
- R5: Opcode 13 clears every event bit whose argument bit is 1, and clears the latch when argument bit 0 is 1. If an event arrives for a bit in the same cycle as its acknowledge, the event wins and the bit stays set.
- R6: Opcode 12 sets status bit 6 (interrupt requested), just as an event would.
- R7: The latch is set when an event arrives on a bit whose indication and enable bits are both 1. `irq` is the latch AND the OR of the event bits that are enabled.
- R8: Opcodes 0, 5, 8 and 11 raise `cmd_busy`, which also reads as `rd_data[12]`. It stays high for exactly BUSY_CYCLES cycles, starting in the cycle after the write.
- R9: A write accepted while `cmd_busy` is high has no effect: the window does not change and nothing is forwarded.
- R10: An accepted opcode other than 1 and 12 to 15 gives a one-cycle `exec_stb` in the cycle after the write, with `exec_op` and `exec_arg` taken from the word. Opcodes 1 and 12 to 15 do not strobe.
- R11: `rd_data[11]` follows the `mst_busy` input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the shared command offset |
| wr_data | input | 16 | Command word: opcode [15:11], argument [10:0] |
| rd_data | output | 16 | Status word with the window in [15:13] |
| evt_in | input | 8 | Event pulses; bit k sets status bit k+1 |
| mst_busy | input | 1 | Bus-master activity level, shown in status bit 11 |
| win_sel | output | 3 | Currently selected register window |
| irq | output | 1 | Level interrupt request |
| cmd_busy | output | 1 | Command in progress |
| exec_stb | output | 1 | Forwarded command strobe |
| exec_op | output | 5 | Opcode of the forwarded command |
| exec_arg | output | 11 | Argument of the forwarded command |

## Verification
Two things can hit the same status bit in one cycle: an acknowledge that clears it and a new event that sets it. The bench provokes this by writing an acknowledge for bits 2 and 4 and pulsing the rx-complete event in that same cycle. The result passes only if bit 4 and the interrupt latch survive while bit 2 is cleared. A second collision is a window-select write that arrives while a reset command is still busy; it is judged by the window field being unchanged once the busy period ends.

// File: rtl/cmdint_pkg.sv
package cmdint_pkg;
   localparam int WORD_W = 16;
   localparam int OP_W   = 5;
   localparam int ARG_W  = 11;
   localparam int SRC_W  = 8;

   localparam logic [OP_W-1:0] OP_GLB_RST  = 5'd0;
   localparam logic [OP_W-1:0] OP_WIN      = 5'd1;
   localparam logic [OP_W-1:0] OP_RX_RST   = 5'd5;
   localparam logic [OP_W-1:0] OP_DISCARD  = 5'd8;
   localparam logic [OP_W-1:0] OP_TX_RST   = 5'd11;
   localparam logic [OP_W-1:0] OP_REQ      = 5'd12;
   localparam logic [OP_W-1:0] OP_ACK      = 5'd13;
   localparam logic [OP_W-1:0] OP_IEN      = 5'd14;
   localparam logic [OP_W-1:0] OP_IND      = 5'd15;

   localparam int BIT_LATCH = 0;
   localparam int BIT_REQ   = 6;
   localparam int BIT_MBUSY = 11;
   localparam int BIT_CBUSY = 12;
   localparam int WIN_LSB   = 13;

   typedef struct packed {
      logic accept;
      logic win;
      logic req;
      logic ack;
      logic ien;
      logic ind;
      logic slow;
      logic fwd;
   } dec_t;
endpackage

// File: rtl/cmdint_decode.sv
module cmdint_decode
   import cmdint_pkg::*;
(
   input  logic              wr_en,
   input  logic [OP_W-1:0]   op,
   input  logic              busy,
   output dec_t              dec
);
   logic acc;
   assign acc = wr_en & ~busy;

   always_comb begin
      dec        = '0;
      dec.accept = acc;
      dec.win    = acc && (op == OP_WIN);
      dec.req    = acc && (op == OP_REQ);
      dec.ack    = acc && (op == OP_ACK);
      dec.ien    = acc && (op == OP_IEN);
      dec.ind    = acc && (op == OP_IND);
      dec.slow   = acc && ((op == OP_GLB_RST) || (op == OP_RX_RST) ||
                           (op == OP_DISCARD) || (op == OP_TX_RST));
      dec.fwd    = acc && !((op == OP_WIN) || (op == OP_REQ) || (op == OP_ACK) ||
                            (op == OP_IEN) || (op == OP_IND));
   end
endmodule

// File: rtl/cmdint_busy_timer.sv
module cmdint_busy_timer #(
   parameter int CYCLES = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy
);
   localparam int CNT_W = $clog2(CYCLES + 1);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)                cnt_q <= '0;
      else if (start)            cnt_q <= CNT_W'(CYCLES);
      else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
   end

   assign busy = (cnt_q != '0);
endmodule

// File: rtl/cmdint_status.sv
module cmdint_status
   import cmdint_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SRC_W-1:0] evt,
   input  logic             req_set,
   input  logic             ack_stb,
   input  logic             ien_stb,
   input  logic             ind_stb,
   input  logic [SRC_W:0]   arg_bits,
   output logic [SRC_W-1:0] src_q,
   output logic             latch_q,
   output logic [SRC_W:0]   ind_q,
   output logic             irq
);
   logic [SRC_W:0]   ien_q;
   logic [SRC_W-1:0] evt_all;
   logic [SRC_W-1:0] src_d;
   logic             arm;

   assign evt_all = evt | (SRC_W'(req_set) << (BIT_REQ - 1));

   for (genvar i = 0; i < SRC_W; i++) begin : g_src
      assign src_d[i] = evt_all[i] | (src_q[i] & ~(ack_stb & arg_bits[i+1]));
   end

   assign arm = |(evt_all & ind_q[SRC_W:1] & ien_q[SRC_W:1]);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         src_q   <= '0;
         latch_q <= 1'b0;
         ien_q   <= '0;
         ind_q   <= '0;
      end else begin
         src_q <= src_d;
         if (arm)                                latch_q <= 1'b1;
         else if (ack_stb && arg_bits[BIT_LATCH]) latch_q <= 1'b0;
         if (ien_stb) ien_q <= arg_bits;
         if (ind_stb) ind_q <= arg_bits;
      end
   end

   assign irq = latch_q & |(src_q & ien_q[SRC_W:1]);
endmodule

// File: rtl/cmdint_regs.sv
module cmdint_regs
   import cmdint_pkg::*;
#(
   parameter int NUM_WIN     = 8,
   parameter int BUSY_CYCLES = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [WORD_W-1:0]        wr_data,
   output logic [WORD_W-1:0]        rd_data,
   input  logic [SRC_W-1:0]         evt_in,
   input  logic                     mst_busy,
   output logic [2:0]               win_sel,
   output logic                     irq,
   output logic                     cmd_busy,
   output logic                     exec_stb,
   output logic [OP_W-1:0]          exec_op,
   output logic [ARG_W-1:0]         exec_arg
);
   localparam int WIN_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1;

   if (NUM_WIN < 2 || NUM_WIN > 8) begin : g_bad_win
      $error("NUM_WIN must lie in 2..8");
   end
   if (BUSY_CYCLES < 1) begin : g_bad_busy
      $error("BUSY_CYCLES must be at least 1");
   end

   dec_t             dec;
   logic [WIN_W-1:0] win_q;
   logic [SRC_W-1:0] src_bits;
   logic [SRC_W:0]   ind_bits;
   logic             latch;

   cmdint_decode u_dec (
      .wr_en (wr_en),
      .op    (wr_data[WORD_W-1 -: OP_W]),
      .busy  (cmd_busy),
      .dec   (dec)
   );

   cmdint_busy_timer #(.CYCLES(BUSY_CYCLES)) u_busy (
      .clk   (clk),
      .rst_n (rst_n),
      .start (dec.slow),
      .busy  (cmd_busy)
   );

   cmdint_status u_stat (
      .clk      (clk),
      .rst_n    (rst_n),
      .evt      (evt_in),
      .req_set  (dec.req),
      .ack_stb  (dec.ack),
      .ien_stb  (dec.ien),
      .ind_stb  (dec.ind),
      .arg_bits (wr_data[SRC_W:0]),
      .src_q    (src_bits),
      .latch_q  (latch),
      .ind_q    (ind_bits),
      .irq      (irq)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         win_q    <= '0;
         exec_stb <= 1'b0;
         exec_op  <= '0;
         exec_arg <= '0;
      end else begin
         if (dec.win) win_q <= wr_data[WIN_W-1:0];
         exec_stb <= dec.fwd;
         if (dec.fwd) begin
            exec_op  <= wr_data[WORD_W-1 -: OP_W];
            exec_arg <= wr_data[ARG_W-1:0];
         end
      end
   end

   if (WIN_W == 3) begin : g_win_full
      assign win_sel = win_q;
   end else begin : g_win_pad
      assign win_sel = {{(3-WIN_W){1'b0}}, win_q};
   end

   always_comb begin
      rd_data                         = '0;
      rd_data[BIT_LATCH]              = latch & ind_bits[BIT_LATCH];
      rd_data[SRC_W:1]                = src_bits & ind_bits[SRC_W:1];
      rd_data[BIT_MBUSY]              = mst_busy;
      rd_data[BIT_CBUSY]              = cmd_busy;
      rd_data[WORD_W-1:WIN_LSB]       = win_sel;
   end
endmodule

// File: rtl/cmdint_chk.sv
module cmdint_chk
   import cmdint_pkg::*;
(
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [WORD_W-1:0] wr_data,
   input logic [SRC_W-1:0]  evt_in,
   input logic [2:0]        win_sel,
   input logic              cmd_busy,
   input logic              exec_stb,
   input logic [SRC_W-1:0]  src_bits,
   input logic              latch,
   input logic              irq
);
   AST_WIN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !cmd_busy && wr_data[15:11] == OP_WIN) |=> (win_sel == $past(wr_data[2:0]))); // R2
   AST_BUSY_HOLDS_WIN: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && cmd_busy) |=> $stable(win_sel)); // R9
   AST_EVT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (|evt_in) |=> ((src_bits & $past(evt_in)) == $past(evt_in))); // R4
   AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !cmd_busy && wr_data[15:11] == OP_ACK)
      |=> ((src_bits & $past(wr_data[SRC_W:1] & ~evt_in)) == '0)); // R5
   AST_REQ_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !cmd_busy && wr_data[15:11] == OP_REQ) |=> src_bits[BIT_REQ-1]); // R6
   AST_IRQ_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> latch); // R7
   AST_FWD_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      exec_stb |-> $past(wr_en && !cmd_busy)); // R10
   AST_BUSY_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cmd_busy) |-> $past(wr_en)); // R8
endmodule

bind cmdint_regs cmdint_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_en    (wr_en),
   .wr_data  (wr_data),
   .evt_in   (evt_in),
   .win_sel  (win_sel),
   .cmd_busy (cmd_busy),
   .exec_stb (exec_stb),
   .src_bits (src_bits),
   .latch    (latch),
   .irq      (irq)
);

// File: tb/tb_cmdint_regs.sv
`timescale 1ns/1ps
module tb_cmdint_regs;
   localparam int NB = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [15:0] wr_data = '0;
   logic [15:0] rd_data;
   logic [7:0]  evt_in = '0;
   logic        mst_busy = 1'b0;
   logic [2:0]  win_sel;
   logic        irq, cmd_busy, exec_stb;
   logic [4:0]  exec_op;
   logic [10:0] exec_arg;

   always #5 clk = ~clk;

   cmdint_regs #(.NUM_WIN(8), .BUSY_CYCLES(NB)) dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .rd_data(rd_data), .evt_in(evt_in), .mst_busy(mst_busy),
      .win_sel(win_sel), .irq(irq), .cmd_busy(cmd_busy),
      .exec_stb(exec_stb), .exec_op(exec_op), .exec_arg(exec_arg)
   );

   typedef struct {
      int          sel;
      logic [15:0] exp;
      string       req;
   } item_t;

   item_t q[$];
   event  check_ev;
   int    total = 0;
   int    fails = 0;
   bit    done  = 1'b0;

   always begin
      @(check_ev);
      while (q.size() > 0) begin
         item_t it;
         logic [15:0] act;
         it = q.pop_front();
         case (it.sel)
            0: act = rd_data;
            1: act = {15'd0, irq};
            2: act = {15'd0, cmd_busy};
            3: act = {15'd0, exec_stb};
            4: act = {11'd0, exec_op};
            5: act = {5'd0, exec_arg};
            default: act = {13'd0, win_sel};
         endcase
         total++;
         if (act !== it.exp) begin
            fails++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", it.req, act, it.exp);
         end
      end
   end

   task automatic expect_v(input int sel, input logic [15:0] exp, input string req);
      item_t it;
      it.sel = sel; it.exp = exp; it.req = req;
      q.push_back(it);
   endtask

   task automatic settle();
      -> check_ev;
      #1;
   endtask

   task automatic drive(input logic we, input logic [15:0] d, input logic [7:0] e);
      @(negedge clk);
      wr_en = we; wr_data = d; evt_in = e;
      @(negedge clk);
      wr_en = 1'b0; evt_in = '0;
   endtask

   function automatic logic [15:0] cw(input int op, input int arg);
      return 16'((op << 11) | (arg & 16'h07FF));
   endfunction

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         fails++; total++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      expect_v(0, 16'h0000, "R1 status"); expect_v(1, 0, "R1 irq");
      expect_v(2, 0, "R1 busy");          expect_v(3, 0, "R1 exec");
      settle();

      drive(1, cw(1, 5), 0);
      expect_v(0, 16'hA000, "R2 window 5"); expect_v(3, 0, "R10 no strobe for window");
      settle();

      drive(0, 0, 8'h02);
      expect_v(0, 16'hA000, "R3 bit hidden by indication"); expect_v(1, 0, "R7 no irq");
      settle();

      drive(1, cw(15, 16'h1FF), 0);
      expect_v(0, 16'hA004, "R4 bit kept, R3 shown"); settle();

      drive(1, cw(14, 16'h1FE), 0);
      expect_v(1, 0, "R7 no latch before event"); settle();

      drive(0, 0, 8'h08);
      expect_v(0, 16'hA015, "R7 latch set"); expect_v(1, 1, "R7 irq high"); settle();

      drive(1, cw(13, 16'h001), 0);
      expect_v(0, 16'hA014, "R5 latch ack"); expect_v(1, 0, "R7 irq low"); settle();

      drive(1, cw(13, 16'h014), 8'h08);
      expect_v(0, 16'hA011, "R5 event beats ack"); expect_v(1, 1, "R7 re-raised"); settle();

      drive(1, cw(12, 0), 0);
      expect_v(0, 16'hA051, "R6 request bit"); settle();

      drive(1, cw(13, 16'h1FF), 0);
      expect_v(0, 16'hA000, "R5 full ack"); expect_v(1, 0, "R5 irq cleared"); settle();

      @(negedge clk); mst_busy = 1'b1; #1;
      expect_v(0, 16'hA800, "R11 bus master busy"); settle();
      mst_busy = 1'b0;

      drive(1, cw(5, 16'h00F), 0);
      expect_v(2, 1, "R8 busy starts"); expect_v(0, 16'hB000, "R8 status bit 12");
      expect_v(3, 1, "R10 strobe"); expect_v(4, 5, "R10 opcode"); expect_v(5, 16'h00F, "R10 argument");
      settle();
      drive(1, cw(1, 2), 0);
      expect_v(3, 0, "R9 no strobe while busy"); settle();
      repeat (NB - 3) @(negedge clk);
      #1; expect_v(2, 1, "R8 busy last cycle"); settle();
      @(negedge clk); #1;
      expect_v(2, 0, "R8 busy ends"); expect_v(0, 16'hA000, "R9 window kept"); settle();

      drive(1, cw(16, 5), 0);
      expect_v(3, 1, "R10 filter strobe"); expect_v(4, 16, "R10 filter op");
      expect_v(2, 0, "R8 no busy for filter"); settle();

      drive(1, cw(14, 0), 0);
      drive(0, 0, 8'h01);
      expect_v(0, 16'hA002, "R4 host error"); expect_v(1, 0, "R7 disabled no latch"); settle();
      drive(1, cw(14, 16'h1FE), 0);
      expect_v(1, 0, "R7 enable alone no latch"); settle();
      drive(1, cw(15, 0), 0);
      drive(0, 0, 8'h02);
      expect_v(0, 16'hA000, "R3 all hidden"); expect_v(1, 0, "R7 unindicated no latch"); settle();

      drive(1, cw(1, 7), 0);
      expect_v(0, 16'hE000, "R2 window 7"); expect_v(6, 7, "R2 win_sel"); settle();

      done = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end
endmodule